// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block turns a latched start address into the word-address stream and the data-valid timing of a synchronous burst read from a 32-bit-wide memory array. A 16-bit configuration word arrives on its own write path. It chooses between the asynchronous and the synchronous read mode, and it sets the first-access latency, the spacing of later words, the burst length, the wrap behaviour and the polarity of the ready output.

When synchronous mode is selected, a clock edge with the active-low latch strobe asserted captures the start address and a snapshot of the configuration. After the first-access latency the block presents one word address per beat to the array and flags each beat on a data-valid strobe. The beats run inside an aligned group of 4 or 8 words, run linearly past that group, or run without limit until a stop request arrives. Holding the advance input low freezes the burst in place.

Top module: `bsq_burst_seq`

## Requirements
- R1: After reset the block is in asynchronous mode (`sync_mode` = 0) with all configuration bits zero, `data_valid` = 0 and `ready_o` = 1, which is the not-ready level for polarity 0.
- R2: While configuration bit 15 is 0, asserting `latch_n` starts nothing, and `data_valid` stays 0.
- R3: A configuration write stores all 16 bits. `sync_mode` follows bit 15. The stored value changes only on a later write or on reset. The fields are: bit 15 selects synchronous read, bit 14 disables standby (stored, no effect here), bits 13..11 hold the first-access latency F, bit 10 is reserved, bit 9 holds the spacing S, bit 8 holds the ready polarity P, bits 7..4 are reserved, bit 3 enables wrap, and bits 2..0 hold the length code.
- R4: In synchronous mode, the rising edge with `latch_n` = 0 captures `addr_in`. Later changes of `addr_in` do not alter the burst.
- R5: `mem_addr` shows the start address from the latch edge onward. `data_valid` first rises at the edge F+2 advancing edges after the latch edge.
- R6: With S = 0, later beats come on every advancing edge. With S = 1 they come on every second advancing edge, and `data_valid` is 0 on the edge in between.
- R7: With wrap enabled and a length of 4 or 8, beat b addresses (start with its low log2(length) bits replaced by those of start+b), so a burst of 4 from 2 gives 2,3,0,1.
- R8: With wrap disabled, beat b addresses start+b, carrying past the group boundary, so a burst of 4 from 3 gives 3,4,5,6.
- R9: Length code 001 gives 4 beats and 010 gives 8 beats. Every other code is continuous and addresses linearly whatever the wrap bit. After the last beat of a finite burst, `data_valid` returns to 0 and `mem_addr` holds the last address.
- R10: On an edge where `burst_adv` is 0, neither `mem_addr`, `data_valid` nor the latency or beat progress changes.
- R11: `burst_stop` high at an edge ends any burst, and `data_valid` is 0 from that edge on. It has priority over a latch on the same edge.
- R12: `ready_o` equals `data_valid` when P = 1 and its inverse when P = 0.
- R13: The burst uses the configuration captured at its latch edge. A write during the burst changes neither its timing, its addresses nor its ready polarity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word to store |
| latch_n | input | 1 | Active-low start-address latch strobe |
| addr_in | input | AW | Start word address |
| burst_adv | input | 1 | Advance enable; 0 holds the burst |
| burst_stop | input | 1 | Ends the current burst |
| mem_addr | output | AW | Word address to the array |
| data_valid | output | 1 | High on an edge that delivers a word |
| ready_o | output | 1 | Valid-data-ready output, polarity from bit 8 |
| sync_mode | output | 1 | Synchronous read mode selected |

## Verification
The assertions assume that `latch_n` is low for one edge per burst. They also assume that `burst_stop` and a latch are never requested together unless stop is meant to win, and that a configuration write carries one clean 16-bit value on the edge where `cfg_we` is high. The bench drives every input at the falling edge, pulses the latch strobe and the write strobe for exactly one cycle, and raises stop only on continuous bursts, after their last checked beat. It sweeps all eight start offsets over every length code class, both wrap settings, varied latencies, both spacings and both polarities. It inserts advance holds and mid-burst configuration writes at chosen beats.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

   localparam int CFG_W = 16;

   typedef struct packed {
      logic       rd_sync;
      logic       stby_dis;
      logic [2:0] first_lat;
      logic       rsv10;
      logic       slow_next;
      logic       rdy_hi;
      logic [3:0] rsv_lo;
      logic       wrap_en;
      logic [2:0] len_code;
   } bsq_cfg_t;

   typedef enum logic [1:0] {LEN4, LEN8, LENC} bsq_len_e;

   typedef enum logic [1:0] {ST_IDLE, ST_LAT, ST_BURST} bsq_state_e;

   function automatic bsq_len_e decode_len(input logic [2:0] code);
      case (code)
         3'b001:  return LEN4;
         3'b010:  return LEN8;
         default: return LENC;
      endcase
   endfunction

   // beats remaining after the first one; zero for continuous
   function automatic logic [2:0] extra_beats(input bsq_len_e len);
      case (len)
         LEN4:    return 3'd3;
         LEN8:    return 3'd7;
         default: return 3'd0;
      endcase
   endfunction

endpackage

// File: rtl/bsq_cfg_reg.sv
module bsq_cfg_reg
   import bsq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   output bsq_cfg_t         cfg
);

   localparam bsq_cfg_t CFG_RST = '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cfg <= CFG_RST;
      else if (we) cfg <= bsq_cfg_t'(wdata);
   end

   // R3: the stored word only moves on a write
   p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(cfg));

endmodule

// File: rtl/bsq_addr_step.sv
module bsq_addr_step
   import bsq_pkg::*;
#(
   parameter int AW = 20
) (
   input  logic [AW-1:0] cur,
   input  bsq_len_e      len,
   input  logic          wrap,
   output logic [AW-1:0] nxt,
   output logic [AW-1:0] grp_mask
);

   localparam int NGRP = 2;   // wrap groups of 4 and 8 words

   logic [AW-1:0] cand [NGRP];
   logic [AW-1:0] gmsk [NGRP];

   if (AW < 4) begin : g_bad_aw
      $error("bsq_addr_step: AW must be at least 4");
   end

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      localparam int GB = g + 2;
      assign cand[g] = {cur[AW-1:GB], cur[GB-1:0] + 1'b1};
      assign gmsk[g] = {{(AW-GB){1'b0}}, {GB{1'b1}}};
   end

   always_comb begin
      nxt      = cur + 1'b1;
      grp_mask = '1;
      if (wrap && len == LEN4) begin
         nxt      = cand[0];
         grp_mask = gmsk[0];
      end else if (wrap && len == LEN8) begin
         nxt      = cand[1];
         grp_mask = gmsk[1];
      end
   end

endmodule

// File: rtl/bsq_seq_core.sv
module bsq_seq_core
   import bsq_pkg::*;
#(
   parameter int AW = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  bsq_cfg_t      cfg,
   input  logic          latch_n,
   input  logic [AW-1:0] addr_in,
   input  logic          adv,
   input  logic          stop,
   input  logic [AW-1:0] nxt_addr,
   input  logic [AW-1:0] grp_mask,
   output logic [AW-1:0] addr_q,
   output logic          dv_q,
   output bsq_len_e      len_s,
   output logic          wrap_s,
   output logic          pol_s
);

   localparam int LAT_MAX = 7 + 2;
   localparam int LCW     = $clog2(LAT_MAX + 1);
   localparam int RW      = 3;

   bsq_state_e    state_q;
   logic [LCW-1:0] lat_cnt_q;
   logic [RW-1:0]  rem_q;
   logic           gap_q;
   logic           slow_s;
   logic [AW-1:0]  base_q;
   logic           latch_go;
   logic           unused_cfg;

   assign latch_go   = cfg.rd_sync && !latch_n;
   assign unused_cfg = ^{cfg.stby_dis, cfg.rsv10, cfg.rsv_lo};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         lat_cnt_q <= '0;
         rem_q     <= '0;
         gap_q     <= 1'b0;
         slow_s    <= 1'b0;
         base_q    <= '0;
         addr_q    <= '0;
         dv_q      <= 1'b0;
         len_s     <= LENC;
         wrap_s    <= 1'b0;
         pol_s     <= 1'b0;
      end else if (stop) begin
         state_q <= ST_IDLE;
         dv_q    <= 1'b0;
      end else if (latch_go) begin
         state_q   <= ST_LAT;
         base_q    <= addr_in;
         addr_q    <= addr_in;
         dv_q      <= 1'b0;
         gap_q     <= 1'b0;
         lat_cnt_q <= LCW'(cfg.first_lat) + LCW'(2);
         rem_q     <= extra_beats(decode_len(cfg.len_code));
         len_s     <= decode_len(cfg.len_code);
         wrap_s    <= cfg.wrap_en;
         slow_s    <= cfg.slow_next;
         pol_s     <= cfg.rdy_hi;
      end else if (adv) begin
         case (state_q)
            ST_LAT: begin
               if (lat_cnt_q == LCW'(1)) begin
                  state_q <= ST_BURST;
                  dv_q    <= 1'b1;
               end else begin
                  lat_cnt_q <= lat_cnt_q - 1'b1;
               end
            end
            ST_BURST: begin
               if (len_s != LENC && rem_q == '0) begin
                  state_q <= ST_IDLE;
                  dv_q    <= 1'b0;
               end else if (slow_s && !gap_q) begin
                  dv_q  <= 1'b0;
                  gap_q <= 1'b1;
               end else begin
                  addr_q <= nxt_addr;
                  dv_q   <= 1'b1;
                  gap_q  <= 1'b0;
                  if (len_s != LENC) rem_q <= rem_q - 1'b1;
               end
            end
            default: dv_q <= 1'b0;
         endcase
      end
   end

   // R9: nothing is flagged outside a burst
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_IDLE |-> !dv_q);

   // R10: a held advance freezes the address and strobe
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && !adv && !stop && !latch_go)
      |=> ($stable(addr_q) && $stable(dv_q)));

   // R7: wrapped beats never leave the aligned group of the start address
   p_wrap_group_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dv_q && wrap_s && len_s != LENC)
      |-> ((addr_q & ~grp_mask) == (base_q & ~grp_mask)));

   // R8: back-to-back linear beats step by one word
   p_seq_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dv_q && $past(dv_q) && $past(state_q == ST_BURST)
       && $past(adv && !stop && !latch_go) && !(wrap_s && len_s != LENC))
      |-> addr_q == $past(addr_q) + 1'b1);

   // R11: a stop request clears the strobe on the next cycle
   p_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> !dv_q);

endmodule

// File: rtl/bsq_burst_seq.sv
module bsq_burst_seq
   import bsq_pkg::*;
#(
   parameter int AW = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [15:0]   cfg_wdata,
   input  logic          latch_n,
   input  logic [AW-1:0] addr_in,
   input  logic          burst_adv,
   input  logic          burst_stop,
   output logic [AW-1:0] mem_addr,
   output logic          data_valid,
   output logic          ready_o,
   output logic          sync_mode
);

   bsq_cfg_t      cfg;
   bsq_len_e      len_s;
   logic          wrap_s;
   logic          pol_s;
   logic [AW-1:0] nxt_addr;
   logic [AW-1:0] grp_mask;

   bsq_cfg_reg u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .cfg   (cfg)
   );

   bsq_addr_step #(.AW(AW)) u_step (
      .cur      (mem_addr),
      .len      (len_s),
      .wrap     (wrap_s),
      .nxt      (nxt_addr),
      .grp_mask (grp_mask)
   );

   bsq_seq_core #(.AW(AW)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg      (cfg),
      .latch_n  (latch_n),
      .addr_in  (addr_in),
      .adv      (burst_adv),
      .stop     (burst_stop),
      .nxt_addr (nxt_addr),
      .grp_mask (grp_mask),
      .addr_q   (mem_addr),
      .dv_q     (data_valid),
      .len_s    (len_s),
      .wrap_s   (wrap_s),
      .pol_s    (pol_s)
   );

   assign ready_o   = pol_s ? data_valid : !data_valid;
   assign sync_mode = cfg.rd_sync;

endmodule

// File: tb/tb_bsq_burst_seq.sv
module tb_bsq_burst_seq;

   localparam int AW = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [15:0]   cfg_wdata = '0;
   logic          latch_n = 1'b1;
   logic [AW-1:0] addr_in = '0;
   logic          burst_adv = 1'b1;
   logic          burst_stop = 1'b0;
   logic [AW-1:0] mem_addr;
   logic          data_valid;
   logic          ready_o;
   logic          sync_mode;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   bsq_burst_seq #(.AW(AW)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_wdata  (cfg_wdata),
      .latch_n    (latch_n),
      .addr_in    (addr_in),
      .burst_adv  (burst_adv),
      .burst_stop (burst_stop),
      .mem_addr   (mem_addr),
      .data_valid (data_valid),
      .ready_o    (ready_o),
      .sync_mode  (sync_mode)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr_cfg(input logic [15:0] v);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_wdata = v;
      @(posedge clk);
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   // one synchronous burst, checked every cycle against arithmetic expectations
   task automatic run_burst(input logic [2:0] lcode, input logic wrap, input logic [2:0] xl,
                            input logic ylat, input logic pol, input logic [AW-1:0] base,
                            input int hold_at, input logic mid_cfg);
      int nb, p, xe, k, holds, lim, j, b;
      logic cont, adv_now, edv;
      logic [AW-1:0] m, ea;
      nb   = (lcode == 3'b001) ? 4 : (lcode == 3'b010) ? 8 : 0;
      cont = (nb == 0);
      p    = ylat ? 2 : 1;
      xe   = int'(xl) + 2;
      m    = AW'(nb - 1);
      wr_cfg({1'b1, 1'b0, xl, 1'b0, ylat, pol, 4'h0, wrap, lcode});
      latch_n = 1'b0;
      addr_in = base;
      @(posedge clk);
      @(negedge clk);
      latch_n = 1'b1;
      addr_in = ~base;   // R4: pins move after the latch edge
      k = 0;
      holds = 0;
      lim = cont ? xe + 14 : xe + (nb - 1) * p + 4;
      if (hold_at < 255) lim = lim + 3;
      for (int c = 0; c <= lim; c++) begin
         if (c > 0) begin
            adv_now = !(k == hold_at && holds < 3);
            if (!adv_now) holds++;
            burst_adv = adv_now;
            if (mid_cfg && k == xe) begin
               cfg_we    = 1'b1;
               cfg_wdata = {1'b1, 1'b1, ~xl, 1'b0, ~ylat, ~pol, 4'hF, ~wrap, 3'b001};
            end
            @(posedge clk);
            @(negedge clk);
            cfg_we = 1'b0;
            if (adv_now) k++;
         end
         if (k < xe) begin
            edv = 1'b0;
            ea  = base;
         end else begin
            j = k - xe;
            b = j / p;
            edv = (j % p) == 0;
            if (!cont && b >= nb) begin
               b   = nb - 1;
               edv = 1'b0;
            end
            if (!cont && wrap) ea = (base & ~m) | ((base + AW'(b)) & m);
            else               ea = base + AW'(b);
         end
         chk((k == xe) ? "R5 first valid" :
             (holds > 0 ? "R6/R10 valid" : (mid_cfg ? "R6/R13 valid" : "R6 valid")),
             32'(data_valid), 32'(edv));
         chk(cont ? "R4/R9 addr" : (wrap ? "R4/R7 addr" : "R4/R8 addr"),
             32'(mem_addr), 32'(ea));
         chk(mid_cfg ? "R12/R13 ready" : "R12 ready", 32'(ready_o), 32'(pol ? edv : !edv));
      end
      burst_adv = 1'b1;
      if (cont) begin
         ea = mem_addr;
         burst_stop = 1'b1;
         latch_n    = 1'b0;   // R11: stop outranks a latch on the same edge
         @(posedge clk);
         @(negedge clk);
         burst_stop = 1'b0;
         latch_n    = 1'b1;
         chk("R11 stop valid", 32'(data_valid), 32'd0);
         chk("R11 stop addr", 32'(mem_addr), 32'(ea));
         @(posedge clk);
         @(negedge clk);
         chk("R11 stays stopped", 32'(data_valid), 32'd0);
      end
   endtask

   task automatic async_latch_check(input string tag);
      @(negedge clk);
      latch_n = 1'b0;
      addr_in = 20'h0ABCD;
      @(posedge clk);
      @(negedge clk);
      latch_n = 1'b1;
      for (int c = 0; c < 12; c++) begin
         chk(tag, 32'(data_valid), 32'd0);
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   initial begin
      logic [2:0] codes [4];
      codes[0] = 3'b001;
      codes[1] = 3'b010;
      codes[2] = 3'b111;
      codes[3] = 3'b011;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset valid", 32'(data_valid), 32'd0);
      chk("R1 reset ready", 32'(ready_o), 32'd1);
      chk("R1 reset mode", 32'(sync_mode), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      async_latch_check("R2 async latch ignored");
      for (int li = 0; li < 4; li++) begin
         for (int w = 0; w < 2; w++) begin
            for (int off = 0; off < 8; off++) begin
               run_burst(codes[li], w[0], 3'((off + li) % 8), off[1] ^ w[0], off[0],
                         AW'(20'h3A7F8 + off), (off == 3) ? 3 + ((off + li) % 8) : 255,
                         off == 5);
               if (li == 0 && w == 0 && off == 0)
                  chk("R3 sync mode set", 32'(sync_mode), 32'd1);
            end
         end
      end
      chk("R3 config retained", 32'(sync_mode), 32'd1);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 mode after reset", 32'(sync_mode), 32'd0);
      chk("R1 ready after reset", 32'(ready_o), 32'd1);
      async_latch_check("R2 latch ignored after reset");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule